// File: doc/BRIEF.md
# Two-Rail Regulator Start-Up Sequencer

This block is the digital start-up controller for a regulator with two outputs: a core rail and an auxiliary rail. It waits in idle until the enable input rises. On that rising edge it captures four things: the target-source mode, the number of populated core phases (from two strap inputs), and a digital target code for each rail. It then holds both reference codes at zero for a fixed 100 µs. After that it raises each active rail's reference by one code step at a fixed interval, so the slope matches 3.25 mV/µs. When every active reference has reached its captured target, it asserts power-good.

Each rail has a comparator flag that is high while the sensed output sits above that rail's reference. While the flag is high, the rail's drivers stay off, which protects a pre-charged output. The drivers turn on once the flag drops, and stay on after that. If the flag never drops, the drivers turn on when soft-start ends. In parallel-target mode the auxiliary rail stays off entirely. Dropping enable or asserting reset clears everything back to idle. The next enable edge captures new settings.

The clock frequency and the reference step size are parameters. The delay and the step interval are computed from them in clock cycles.

Top module: `softstart_seq`

## Requirements
- R1: After reset, both reference codes are 0, both driver enables are 0, power-good is 0 and the phase count output is 0.
- R2: mode_sel_i is sampled on the enable rising edge (1 = serial-target mode, both rails start; 0 = parallel-target mode, core rail only). Later changes to mode_sel_i have no effect until enable drops.
- R3: The phase count is captured on the enable edge and presented as a binary number on phase_cnt_o. It is 3 when only strap4_i is high, 2 when strap3_i and strap4_i are both high, and 4 otherwise.
- R4: Both target codes are captured on the enable edge. Later changes to core_tgt_i or aux_tgt_i do not alter the ramp or its end point until enable drops.
- R5: In parallel-target mode, aux_ref_o and aux_drv_en_o stay 0, and power-good depends on the core rail only.
- R6: With the enable edge at clock edge E, both references stay 0 through edge E+DLY, where DLY is 100 µs in clock cycles.
- R7: After the delay, an active rail's reference rises by exactly 1 every STP cycles and stops at its target. At edge E+DLY+k, the reference is min(k/STP, target), using integer division.
- R8: Power-good rises at edge E+DLY+STP*M+1, where M is the larger active target (a zero target included), and stays high while enable is high.
- R9: While a rail's feedback-above flag is high, that rail's driver enable stays 0. One edge after the flag is seen low in the delay or ramp phase, the driver enable goes to 1 and stays 1.
- R10: If the feedback-above flag stays high for the whole ramp, the driver enable rises on the same edge as power-good.
- R11: One edge after en_i is sampled low, both references, both driver enables, power-good and the phase count are 0. A later enable edge starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; its rising edge starts soft-start |
| mode_sel_i | input | 1 | Target-source select, sampled on enable edge (1 = serial) |
| strap3_i | input | 1 | Third-phase strap, high when the phase is unpopulated |
| strap4_i | input | 1 | Fourth-phase strap, high when the phase is unpopulated |
| core_tgt_i | input | CODE_W | Core rail target code |
| aux_tgt_i | input | CODE_W | Auxiliary rail target code |
| core_fb_hi_i | input | 1 | Core output above core reference |
| aux_fb_hi_i | input | 1 | Auxiliary output above auxiliary reference |
| core_ref_o | output | CODE_W | Core reference code |
| aux_ref_o | output | CODE_W | Auxiliary reference code |
| core_drv_en_o | output | 1 | Core driver enable |
| aux_drv_en_o | output | 1 | Auxiliary driver enable |
| phase_cnt_o | output | 3 | Number of active core phases |
| pgood_o | output | 1 | Power-good |

## Verification
The hardest case to reach is a pre-biased output released in the middle of a ramp. It needs the feedback flag held high across the enable edge, then dropped at a chosen cycle, and the driver enable must then rise exactly one edge later. The bench drives the flag from its own cycle counter, counted from the enable edge. It covers three cases: the flag released mid-ramp, the flag never released, and the flag low throughout. Another hard case is proving that inputs change nothing after the enable edge. For this, the bench flips mode_sel_i and both target codes a few cycles after the edge, and every cycle it compares the reference codes with values computed from the originally captured settings.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } ss_state_e;

  localparam int NUM_RAILS = 2;
  localparam int RAIL_CORE = 0;
  localparam int RAIL_AUX  = 1;

  // 100 us fixed pre-ramp delay in cycles
  function automatic int calc_delay_cyc(input longint clk_hz);
    longint c;
    c = clk_hz / 64'd10_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // cycles per LSB at 3.25 mV/us, rounded to nearest
  function automatic int calc_step_cyc(input longint clk_hz, input longint lsb_uv);
    longint c;
    c = (clk_hz * lsb_uv + 64'd1_625_000_000) / 64'd3_250_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/ss_phase_decode.sv
module ss_phase_decode (
  input  logic       strap3_i,
  input  logic       strap4_i,
  output logic [2:0] nph_o
);
  always_comb begin
    unique case ({strap3_i, strap4_i})
      2'b01:   nph_o = 3'd3;
      2'b11:   nph_o = 3'd2;
      default: nph_o = 3'd4;
    endcase
  end
endmodule

// File: rtl/ss_tick_timer.sv
module ss_tick_timer #(
  parameter int DLY_CYC = 100,
  parameter int STP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic dly_hit_o,
  output logic stp_hit_o
);
  localparam int MAXC = (DLY_CYC > STP_CYC) ? DLY_CYC : STP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] STP_LAST = CW'(STP_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAXC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign dly_hit_o = (cnt_q == DLY_LAST);
  assign stp_hit_o = (cnt_q == STP_LAST);
endmodule

// File: rtl/ss_rail_ramp.sv
module ss_rail_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              act_i,
  input  logic [CODE_W-1:0] tgt_i,
  input  logic              step_i,
  input  logic              run_i,
  input  logic              finish_i,
  input  logic              fb_hi_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              drv_en_o,
  output logic              done_o
);
  logic              act_q;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] ref_q;
  logic              drv_q;
  logic              at_tgt;

  assign at_tgt = (ref_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      tgt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      tgt_q <= '0;
    end else if (start_i) begin
      act_q <= act_i;
      tgt_q <= act_i ? tgt_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ref_q <= '0;
    else if (clr_i || start_i)           ref_q <= '0;
    else if (step_i && act_q && !at_tgt) ref_q <= ref_q + 1'b1;
  end

  // drivers held off while output sits above the reference; sticky once on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           drv_q <= 1'b0;
    else if (clr_i || start_i)             drv_q <= 1'b0;
    else if (act_q && finish_i)            drv_q <= 1'b1;
    else if (act_q && run_i && !fb_hi_i)   drv_q <= 1'b1;
  end

  assign ref_o    = ref_q;
  assign drv_en_o = drv_q;
  assign done_o   = !act_q || at_tgt;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int CLK_HZ    = 1_000_000,
  parameter int LSB_UV    = 12_500,
  localparam int DLY_CYC  = calc_delay_cyc(longint'(CLK_HZ)),
  localparam int STP_CYC  = calc_step_cyc(longint'(CLK_HZ), longint'(LSB_UV))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_sel_i,
  input  logic              strap3_i,
  input  logic              strap4_i,
  input  logic [CODE_W-1:0] core_tgt_i,
  input  logic [CODE_W-1:0] aux_tgt_i,
  input  logic              core_fb_hi_i,
  input  logic              aux_fb_hi_i,
  output logic [CODE_W-1:0] core_ref_o,
  output logic [CODE_W-1:0] aux_ref_o,
  output logic              core_drv_en_o,
  output logic              aux_drv_en_o,
  output logic [2:0]        phase_cnt_o,
  output logic              pgood_o
);
  ss_state_e state_q, state_d;
  logic en_q;
  logic start, clr, run, finish, step, all_done;
  logic dly_hit, stp_hit, tmr_load;
  logic [2:0] nph_dec, nph_q;

  logic [CODE_W-1:0] rail_tgt [NUM_RAILS];
  logic [CODE_W-1:0] rail_ref [NUM_RAILS];
  logic              rail_act [NUM_RAILS];
  logic              rail_fb  [NUM_RAILS];
  logic              rail_drv [NUM_RAILS];
  logic [NUM_RAILS-1:0] rail_done;

  assign rail_tgt[RAIL_CORE] = core_tgt_i;
  assign rail_tgt[RAIL_AUX]  = aux_tgt_i;
  assign rail_act[RAIL_CORE] = 1'b1;
  assign rail_act[RAIL_AUX]  = mode_sel_i;
  assign rail_fb[RAIL_CORE]  = core_fb_hi_i;
  assign rail_fb[RAIL_AUX]   = aux_fb_hi_i;

  assign clr      = !en_i;
  assign start    = (state_q == ST_IDLE) && en_i && !en_q;
  assign run      = (state_q == ST_DELAY) || (state_q == ST_RAMP);
  assign all_done = &rail_done;
  assign finish   = en_i && (state_q == ST_RAMP) && all_done;
  assign step     = en_i && (state_q == ST_RAMP) && stp_hit && !all_done;
  assign tmr_load = clr || start || step || ((state_q == ST_DELAY) && dly_hit);

  always_comb begin
    state_d = state_q;
    if (clr) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  if (start)    state_d = ST_DELAY;
        ST_DELAY: if (dly_hit)  state_d = ST_RAMP;
        ST_RAMP:  if (all_done) state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      nph_q   <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_i;
      if (clr)        nph_q <= '0;
      else if (start) nph_q <= nph_dec;
    end
  end

  ss_phase_decode u_phase (
    .strap3_i (strap3_i),
    .strap4_i (strap4_i),
    .nph_o    (nph_dec)
  );

  ss_tick_timer #(
    .DLY_CYC (DLY_CYC),
    .STP_CYC (STP_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .dly_hit_o (dly_hit),
    .stp_hit_o (stp_hit)
  );

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    ss_rail_ramp #(
      .CODE_W (CODE_W)
    ) u_rail (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .start_i  (start),
      .act_i    (rail_act[g]),
      .tgt_i    (rail_tgt[g]),
      .step_i   (step),
      .run_i    (run),
      .finish_i (finish),
      .fb_hi_i  (rail_fb[g]),
      .ref_o    (rail_ref[g]),
      .drv_en_o (rail_drv[g]),
      .done_o   (rail_done[g])
    );
  end

  assign core_ref_o    = rail_ref[RAIL_CORE];
  assign aux_ref_o     = rail_ref[RAIL_AUX];
  assign core_drv_en_o = rail_drv[RAIL_CORE];
  assign aux_drv_en_o  = rail_drv[RAIL_AUX];
  assign phase_cnt_o   = nph_q;
  assign pgood_o       = (state_q == ST_DONE);
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [CODE_W-1:0] core_ref_o,
  input logic [CODE_W-1:0] aux_ref_o,
  input logic              core_drv_en_o,
  input logic              aux_drv_en_o,
  input logic [2:0]        phase_cnt_o,
  input logic              pgood_o
);
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (core_ref_o == '0 && aux_ref_o == '0 && !core_drv_en_o &&
               !aux_drv_en_o && !pgood_o && phase_cnt_o == 3'd0)); // R11

  AST_CORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i) |-> (core_ref_o == $past(core_ref_o) ||
                               core_ref_o == $past(core_ref_o) + CODE_W'(1))); // R7

  AST_AUX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i) |-> (aux_ref_o == $past(aux_ref_o) ||
                               aux_ref_o == $past(aux_ref_o) + CODE_W'(1))); // R7

  AST_PG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgood_o && en_i) |=> pgood_o); // R8

  AST_PG_DRV_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> core_drv_en_o); // R10

  AST_DRV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_drv_en_o && en_i) |=> core_drv_en_o); // R9

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_cnt_o inside {3'd0, 3'd2, 3'd3, 3'd4}); // R3
endmodule

bind softstart_seq softstart_seq_chk #(
  .CODE_W (CODE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .core_ref_o    (core_ref_o),
  .aux_ref_o     (aux_ref_o),
  .core_drv_en_o (core_drv_en_o),
  .aux_drv_en_o  (aux_drv_en_o),
  .phase_cnt_o   (phase_cnt_o),
  .pgood_o       (pgood_o)
);

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 8;
  localparam int CLK_HZ = 1_000_000;
  localparam int LSB_UV = 12_500;
  localparam int DLY = CLK_HZ / 10_000;
  localparam int STP = int'((longint'(CLK_HZ) * LSB_UV + 64'd1_625_000_000) / 64'd3_250_000_000);
  localparam int NEVER = 1_000_000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, mode_sel_i = 1'b0, strap3_i = 1'b0, strap4_i = 1'b0;
  logic [W-1:0] core_tgt_i = '0, aux_tgt_i = '0;
  logic core_fb_hi_i = 1'b0, aux_fb_hi_i = 1'b0;
  logic [W-1:0] core_ref_o, aux_ref_o;
  logic core_drv_en_o, aux_drv_en_o, pgood_o;
  logic [2:0] phase_cnt_o;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  softstart_seq #(.CODE_W(W), .CLK_HZ(CLK_HZ), .LSB_UV(LSB_UV)) u_softstart_seq (
    .clk_i, .rst_ni, .en_i, .mode_sel_i, .strap3_i, .strap4_i,
    .core_tgt_i, .aux_tgt_i, .core_fb_hi_i, .aux_fb_hi_i,
    .core_ref_o, .aux_ref_o, .core_drv_en_o, .aux_drv_en_o,
    .phase_cnt_o, .pgood_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ramp_val(input int c, input int t);
    int v;
    if (c < DLY) return 0;
    v = (c - DLY) / STP;
    return (v > t) ? t : v;
  endfunction

  task automatic check_idle(input string req);
    chk(core_ref_o == '0, {req, " core_ref"}, int'(core_ref_o), 0);
    chk(aux_ref_o == '0, {req, " aux_ref"}, int'(aux_ref_o), 0);
    chk(!core_drv_en_o, {req, " core_drv"}, int'(core_drv_en_o), 0);
    chk(!aux_drv_en_o, {req, " aux_drv"}, int'(aux_drv_en_o), 0);
    chk(!pgood_o, {req, " pgood"}, int'(pgood_o), 0);
    chk(phase_cnt_o == 3'd0, {req, " phase"}, int'(phase_cnt_o), 0);
  endtask

  task automatic run_seq(input bit mode, input int tc, input int ta, input bit s3,
                         input bit s4, input int rel, input int abort_at,
                         input bit flip, input string tag);
    int mx, pgt, last, enph, drv_at, ec, ea;
    @(negedge clk_i);
    mode_sel_i = mode; core_tgt_i = W'(tc); aux_tgt_i = W'(ta);
    strap3_i = s3; strap4_i = s4;
    core_fb_hi_i = (rel > 0); aux_fb_hi_i = 1'b0;
    en_i = 1'b1;
    mx   = (mode && ta > tc) ? ta : tc;
    pgt  = DLY + STP * mx + 1;
    last = (abort_at >= 0) ? abort_at : pgt + 3;
    enph = (s4 && !s3) ? 3 : (s3 && s4) ? 2 : 4;
    drv_at = (rel + 1 < pgt) ? rel + 1 : pgt;
    for (int c = 0; c <= last; c++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      ec = ramp_val(c, tc);
      ea = mode ? ramp_val(c, ta) : 0;
      chk(core_ref_o == W'(ec), {"R6 R7 core_ref ", tag}, int'(core_ref_o), ec);
      chk(aux_ref_o == W'(ea), {"R5 R7 aux_ref ", tag}, int'(aux_ref_o), ea);
      chk(pgood_o == (c >= pgt), {"R8 pgood ", tag}, int'(pgood_o), int'(c >= pgt));
      chk(core_drv_en_o == (c >= drv_at), {"R9 R10 core_drv ", tag},
          int'(core_drv_en_o), int'(c >= drv_at));
      chk(aux_drv_en_o == (mode && c >= 1), {"R5 aux_drv ", tag},
          int'(aux_drv_en_o), int'(mode && c >= 1));
      chk(phase_cnt_o == 3'(enph), {"R3 phase ", tag}, int'(phase_cnt_o), enph);
      if (flip && c == 5) begin
        mode_sel_i = !mode; strap3_i = !s3; strap4_i = !s4;
        core_tgt_i = W'(tc + 9); aux_tgt_i = W'(ta + 13);
      end
      if (c == rel) core_fb_hi_i = 1'b0;
    end
    en_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check_idle({"R11 ", tag});
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check_idle("R1 idle");
    run_seq(1'b1, 20, 35, 1'b0, 1'b0, 0, -1, 1'b0, "serial 4ph");
    run_seq(1'b1, 35, 20, 1'b0, 1'b1, 0, -1, 1'b0, "serial 3ph");
    run_seq(1'b0, 25, 40, 1'b1, 1'b1, 0, -1, 1'b0, "R5 parallel 2ph");
    run_seq(1'b0, 0, 7, 1'b1, 1'b0, 0, -1, 1'b0, "parallel zero tgt");
    run_seq(1'b1, 0, 0, 1'b0, 1'b0, 0, -1, 1'b0, "serial zero tgts");
    run_seq(1'b1, 30, 10, 1'b0, 1'b0, DLY + STP * 10, -1, 1'b0, "R9 prebias mid");
    run_seq(1'b1, 6, 3, 1'b0, 1'b1, 40, -1, 1'b0, "R9 prebias in delay");
    run_seq(1'b0, 15, 0, 1'b0, 1'b0, NEVER, -1, 1'b0, "R10 prebias above");
    run_seq(1'b1, 12, 18, 1'b0, 1'b1, 0, -1, 1'b1, "R2 R4 flip serial");
    run_seq(1'b0, 22, 18, 1'b1, 1'b1, 0, -1, 1'b1, "R2 R4 flip parallel");
    run_seq(1'b1, 40, 40, 1'b0, 1'b0, 0, DLY + STP * 5, 1'b0, "R11 abort ramp");
    run_seq(1'b1, 40, 40, 1'b0, 1'b0, 0, DLY / 2, 1'b0, "R11 abort delay");
    run_seq(1'b1, 255, 1, 1'b1, 1'b0, 0, -1, 1'b0, "R7 full scale");
    // R1: reset mid-ramp returns to idle
    @(negedge clk_i);
    mode_sel_i = 1'b1; core_tgt_i = 8'd50; aux_tgt_i = 8'd50; en_i = 1'b1;
    repeat (DLY + 20) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_idle("R1 async reset");
    en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_idle("R1 after reset");
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk_i);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule